// File: doc/BRIEF.md
# SPI Master Engine with Programmable Frame Timing

This block is a single-lane SPI master. Software writes words into a four-deep transmit queue through a small register port. The engine turns each word into one frame on SCK/SOUT under one of four active-low chip-select lines. The bits it samples on SIN go into a four-deep receive queue, which software drains by reading the receive data address.

All frame timing is counted in ticks of a prescaled clock, which runs at the functional clock divided by a power of two. Four separate counts are programmed: the SCK period, the delay from chip-select assertion to the first SCK edge, the delay from the last SCK edge to chip-select release, and the minimum released gap before the next frame. Status bits are derived from programmable queue watermarks and from frame completion, so a polling loop can pace the writes and detect the end of a transfer without interrupts.

Register map (word addresses): 0 control, 1 status, 2 command, 3 timing, 4 watermarks, 5 transmit data (write), 6 receive data (read). A read returns its data in the same cycle as the read strobe.

Top module: `spi_cmd_master`

## Requirements
- R1: After reset all four chip-select lines are high, SCK and SOUT are low, and status (addr 1) reads 0x1: bit0 tx_req=1, bit1 rx_rdy=0, bit2 done=0, bit3 tx_err=0, bit4 busy=0.
- R2: A frame carries cmd[7:3]+1 bits. With cmd[2]=0 the most significant frame bit is shifted first. With cmd[2]=1 bit 0 is shifted first. Only the low cmd[7:3]+1 bits of the word are sent.
- R3: cmd[0] is the SCK idle level and SCK does not move while no chip select is asserted. With cmd[1]=0 SOUT is valid before the leading edge and is sampled on it. With cmd[1]=1 SOUT changes on the leading edge and SIN is sampled on the trailing edge.
- R4: One SCK period lasts (timing[7:0]+2)·2^cmd[10:8] functional clock cycles.
- R5: The first SCK edge follows chip-select assertion by (timing[15:8]+1)·2^cmd[10:8] cycles.
- R6: Chip-select release follows the last SCK edge by (timing[23:16]+1)·2^cmd[10:8] cycles.
- R7: Between back-to-back frames the chip select stays released for (timing[31:24]+2)·2^cmd[10:8] cycles.
- R8: Only the line numbered cmd[12:11] of pcs_no is driven low during a frame; at most one line is ever low.
- R9: Status bit0 is 1 exactly when the transmit queue count is at or below watermark[2:0]. Writing status bit0 has no effect.
- R10: Status bit1 is 1 exactly when the receive queue count is above watermark[6:4]. A read of addr 6 returns the oldest received word, right-justified, and removes it.
- R11: Status bit2 is set when a frame's chip select is released and is cleared by writing 1 to it.
- R12: A write to addr 5 while four words are queued is dropped and sets status bit3, which is cleared by writing 1 to it; the queued words are sent unchanged.
- R13: Writes to command, timing and watermark addresses are ignored while control bit0 (enable) is 1.
- R14: With cmd[13]=0 no frame starts while the receive queue is full, and SOUT keeps its last value while all chip selects are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data |
| sin_i | input | 1 | Serial data in |
| sck_o | output | 1 | Serial clock |
| sout_o | output | 1 | Serial data out |
| pcs_no | output | 4 | Chip selects, active low |

## Verification
The hardest state to reach from the ports is the receive-queue stall: a frame must be pending while the receive queue is full. The bench loops SOUT back to SIN and lets four frames complete with no reads. It then queues two more words and watches that no chip select moves until the first receive read frees a slot. Frame timing is measured on the serial pins in clock cycles and compared with the programmed counts under two prescaler settings and two clock modes.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned FW = $clog2(DW);
  localparam int unsigned PRE_W = 3;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_STAT  = 3'd1,
    A_CMD   = 3'd2,
    A_TIME  = 3'd3,
    A_WATER = 3'd4,
    A_TXD   = 3'd5,
    A_RXD   = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic             nostall;
    logic [1:0]       cs;
    logic [PRE_W-1:0] pre;
    logic [FW-1:0]    fsz;
    logic             lsb;
    logic             cpha;
    logic             cpol;
  } cmd_t;

  typedef struct packed {
    logic [7:0] gap;
    logic [7:0] trail;
    logic [7:0] lead;
    logic [7:0] div;
  } timing_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HALF1,
    ST_HALF2,
    ST_TRAIL
  } eng_state_e;
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = $clog2(DEPTH+1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign do_push = push_i && (cnt != CW'(DEPTH));
  assign do_pop  = pop_i && (cnt != '0);
  assign rdata_o = mem[rp];
  assign count_o = cnt;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/spi_prescaler.sv
module spi_prescaler #(
  parameter int unsigned PRE_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = (1 << PRE_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] mask;

  assign span   = (CNT_W+1)'(1) << pre_i;
  assign mask   = CNT_W'(span - 1'b1);
  assign tick_o = en_i && ((cnt & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt <= '0;
    else if (!en_i) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_cmd_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  cmd_t          cmd_i,
  input  timing_t       tim_i,
  input  logic          tx_valid_i,
  input  logic [DW-1:0] tx_word_i,
  input  logic          rx_full_i,
  input  logic          sin_i,
  output logic          tx_pop_o,
  output logic          rx_push_o,
  output logic [DW-1:0] rx_word_o,
  output logic          sck_o,
  output logic          sout_o,
  output logic [3:0]    pcs_no,
  output logic          busy_o
);
  eng_state_e    state;
  logic [8:0]    cnt, gap_cnt;
  logic [8:0]    per, h1, h2;
  logic [FW-1:0] idx, pos, pos_nx, pos0;
  logic          sck_act, sout_q;
  logic [3:0]    pcs_q;
  logic [DW-1:0] tx_sh, rx_sh;
  logic          start_ok, at_zero;

  // half-periods split the SCK period; the first half takes the floor
  assign per = {1'b0, tim_i.div} + 9'd2;
  assign h1  = per >> 1;
  assign h2  = per - h1;

  assign pos    = cmd_i.lsb ? idx : cmd_i.fsz - idx;
  assign pos_nx = cmd_i.lsb ? idx + 1'b1 : cmd_i.fsz - idx - 1'b1;
  assign pos0   = cmd_i.lsb ? '0 : cmd_i.fsz;

  assign start_ok = tx_valid_i && (cmd_i.nostall || !rx_full_i);
  assign at_zero  = (cnt == '0);

  assign tx_pop_o  = en_i && tick_i && (state == ST_IDLE) && (gap_cnt == '0) && start_ok;
  assign rx_push_o = en_i && tick_i && (state == ST_TRAIL) && at_zero;
  assign rx_word_o = rx_sh;
  assign sck_o     = cmd_i.cpol ^ sck_act;
  assign sout_o    = sout_q;
  assign pcs_no    = pcs_q;
  assign busy_o    = (state != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      gap_cnt <= '0;
      idx     <= '0;
      sck_act <= 1'b0;
      sout_q  <= 1'b0;
      pcs_q   <= '1;
      tx_sh   <= '0;
      rx_sh   <= '0;
    end else if (!en_i) begin
      state   <= ST_IDLE;
      gap_cnt <= '0;
      sck_act <= 1'b0;
      pcs_q   <= '1;
    end else if (tick_i) begin
      case (state)
        ST_IDLE: begin
          if (gap_cnt != '0) begin
            gap_cnt <= gap_cnt - 1'b1;
          end else if (start_ok) begin
            tx_sh <= tx_word_i;
            rx_sh <= '0;
            idx   <= '0;
            pcs_q <= ~(4'b0001 << cmd_i.cs);
            cnt   <= {1'b0, tim_i.lead};
            state <= ST_LEAD;
            if (!cmd_i.cpha) sout_q <= tx_word_i[pos0];
          end
        end
        ST_LEAD, ST_HALF2: begin
          if (at_zero) begin
            // leading edge
            sck_act <= 1'b1;
            if (cmd_i.cpha) sout_q <= tx_sh[pos];
            else            rx_sh[pos] <= sin_i;
            cnt   <= h1 - 1'b1;
            state <= ST_HALF1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HALF1: begin
          if (at_zero) begin
            // trailing edge
            sck_act <= 1'b0;
            if (cmd_i.cpha) rx_sh[pos] <= sin_i;
            if (idx == cmd_i.fsz) begin
              cnt   <= {1'b0, tim_i.trail};
              state <= ST_TRAIL;
            end else begin
              idx <= idx + 1'b1;
              if (!cmd_i.cpha) sout_q <= tx_sh[pos_nx];
              cnt   <= h2 - 1'b1;
              state <= ST_HALF2;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_TRAIL: begin
          if (at_zero) begin
            pcs_q   <= '1;
            gap_cnt <= {1'b0, tim_i.gap} + 9'd1;
            state   <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
  import spi_cmd_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        sin_i,
  output logic        sck_o,
  output logic        sout_o,
  output logic [3:0]  pcs_no
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic          en_q, done_q, err_q;
  cmd_t          cmd_q;
  timing_t       tim_q;
  logic [CW-1:0] txw_q, rxw_q;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [DW-1:0] tx_head, rx_head, rx_word;
  logic          tx_push, tx_pop, rx_push, rx_pop;
  logic          tx_full, rx_full, tx_req, rx_rdy;
  logic          tick, busy, cfg_ok;
  logic          wr_ctrl, wr_stat, wr_cmd, wr_time, wr_water;
  logic [31:0]   water_rd;

  assign wr_ctrl  = wr_en_i && (addr_i == A_CTRL);
  assign wr_stat  = wr_en_i && (addr_i == A_STAT);
  assign wr_cmd   = wr_en_i && (addr_i == A_CMD);
  assign wr_time  = wr_en_i && (addr_i == A_TIME);
  assign wr_water = wr_en_i && (addr_i == A_WATER);
  assign tx_push  = wr_en_i && (addr_i == A_TXD);
  assign rx_pop   = rd_en_i && (addr_i == A_RXD);
  assign cfg_ok   = !en_q;

  assign tx_full = (tx_cnt == CW'(DEPTH));
  assign rx_full = (rx_cnt == CW'(DEPTH));
  assign tx_req  = (tx_cnt <= txw_q);
  assign rx_rdy  = (rx_cnt > rxw_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      cmd_q  <= '{nostall: 1'b0, cs: 2'd0, pre: '0, fsz: FW'(DW-1),
                  lsb: 1'b0, cpha: 1'b0, cpol: 1'b0};
      tim_q  <= '0;
      txw_q  <= '0;
      rxw_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wr_ctrl) en_q <= wdata_i[0];
      if (wr_cmd && cfg_ok)  cmd_q <= cmd_t'(wdata_i[$bits(cmd_t)-1:0]);
      if (wr_time && cfg_ok) tim_q <= timing_t'(wdata_i);
      if (wr_water && cfg_ok) begin
        txw_q <= wdata_i[CW-1:0];
        rxw_q <= wdata_i[4 +: CW];
      end
      // set wins over a same-cycle clear
      if (rx_push)                     done_q <= 1'b1;
      else if (wr_stat && wdata_i[2])  done_q <= 1'b0;
      if (tx_push && tx_full)          err_q <= 1'b1;
      else if (wr_stat && wdata_i[3])  err_q <= 1'b0;
    end
  end

  always_comb begin
    water_rd = '0;
    water_rd[CW-1:0] = txw_q;
    water_rd[4 +: CW] = rxw_q;
  end

  always_comb begin
    case (reg_addr_e'(addr_i))
      A_CTRL:  rdata_o = {31'b0, en_q};
      A_STAT:  rdata_o = {27'b0, busy, err_q, done_q, rx_rdy, tx_req};
      A_CMD:   rdata_o = {{(32-$bits(cmd_t)){1'b0}}, cmd_q};
      A_TIME:  rdata_o = tim_q;
      A_WATER: rdata_o = water_rd;
      A_RXD:   rdata_o = rx_head;
      default: rdata_o = '0;
    endcase
  end

  spi_fifo #(.W(DW), .DEPTH(DEPTH), .CW(CW)) u_txq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (tx_push),
    .wdata_i (wdata_i),
    .pop_i   (tx_pop),
    .rdata_o (tx_head),
    .count_o (tx_cnt)
  );

  spi_fifo #(.W(DW), .DEPTH(DEPTH), .CW(CW)) u_rxq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push),
    .wdata_i (rx_word),
    .pop_i   (rx_pop),
    .rdata_o (rx_head),
    .count_o (rx_cnt)
  );

  spi_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_q),
    .pre_i  (cmd_q.pre),
    .tick_o (tick)
  );

  spi_frame_engine u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_q),
    .tick_i     (tick),
    .cmd_i      (cmd_q),
    .tim_i      (tim_q),
    .tx_valid_i (tx_cnt != '0),
    .tx_word_i  (tx_head),
    .rx_full_i  (rx_full),
    .sin_i      (sin_i),
    .tx_pop_o   (tx_pop),
    .rx_push_o  (rx_push),
    .rx_word_o  (rx_word),
    .sck_o      (sck_o),
    .sout_o     (sout_o),
    .pcs_no     (pcs_no),
    .busy_o     (busy)
  );
endmodule

// File: rtl/spi_cmd_master_chk.sv
module spi_cmd_master_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          done_i,
  input logic          sck_i,
  input logic          sout_i,
  input logic [3:0]    pcs_i,
  input logic [CW-1:0] tx_cnt_i,
  input logic [CW-1:0] rx_cnt_i
);
  // R8
  one_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~pcs_i));

  // R14
  sout_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&pcs_i && $past(&pcs_i)) |-> $stable(sout_i));

  // R3
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&pcs_i && $past(&pcs_i) && en_i && $past(en_i)) |-> $stable(sck_i));

  // R11
  done_on_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(&pcs_i) && en_i) |-> done_i);

  // R11
  done_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> $rose(&pcs_i));

  // R12
  tx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt_i <= CW'(DEPTH));

  // R10
  rx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt_i <= CW'(DEPTH));
endmodule

bind spi_cmd_master spi_cmd_master_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_q),
  .done_i   (done_q),
  .sck_i    (sck_o),
  .sout_i   (sout_o),
  .pcs_i    (pcs_no),
  .tx_cnt_i (tx_cnt),
  .rx_cnt_i (rx_cnt)
);

// File: tb/sim_spi_cmd_master.sv
module sim_spi_cmd_master;
  localparam logic [2:0] AD_CTRL = 3'd0, AD_STAT = 3'd1, AD_CMD = 3'd2,
                         AD_TIME = 3'd3, AD_WATER = 3'd4, AD_TXD = 3'd5,
                         AD_RXD = 3'd6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        sin, sck, sout;
  logic [3:0]  pcs;

  assign sin = sout;  // loopback

  always #5 clk = ~clk;

  spi_cmd_master u0 (
    .clk_i (clk), .rst_ni (rst_n), .wr_en_i (we), .rd_en_i (re),
    .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata),
    .sin_i (sin), .sck_o (sck), .sout_o (sout), .pcs_no (pcs)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  // serial-side model of the active configuration
  logic       m_cpol = 0, m_cpha = 0, m_lsb = 0;
  int         m_fsz = 31;
  logic [3:0] m_sel = 4'hE;

  logic [31:0] exp_q[$];
  int frames_seen = 0;
  int lead_meas, trail_meas, per_meas, gap_meas;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  function automatic logic [31:0] fmask(input int fsz);
    return (fsz >= 31) ? 32'hFFFF_FFFF : ((32'h1 << (fsz + 1)) - 32'h1);
  endfunction

  function automatic logic [31:0] mk_cmd(input bit cpol, input bit cpha, input bit lsb,
                                         input int fsz, input int pre, input int cs,
                                         input bit nostall);
    return {18'b0, nostall, 2'(cs), 3'(pre), 5'(fsz), lsb, cpha, cpol};
  endfunction

  task automatic config_cmd(input bit cpol, input bit cpha, input bit lsb,
                            input int fsz, input int pre, input int cs, input bit nostall);
    m_cpol = cpol; m_cpha = cpha; m_lsb = lsb; m_fsz = fsz;
    m_sel = ~(4'b0001 << cs);
    wr(AD_CMD, mk_cmd(cpol, cpha, lsb, fsz, pre, cs, nostall));
  endtask

  // driver: record the expected serial word, then queue it in the design
  task automatic send(input logic [31:0] w, input bit accepted);
    if (accepted) exp_q.push_back(w & fmask(m_fsz));
    wr(AD_TXD, w);
  endtask

  task automatic wait_frames(input int n);
    while (frames_seen < n) @(posedge clk);
  endtask

  // monitor: rebuild each frame from the pins and compare with the queue
  initial begin : mon
    logic [3:0]  prev_pcs = 4'hF;
    logic        prev_sck = 1'b0;
    logic [31:0] cap = '0;
    int nb = 0, n_edge = 0, t_fall = 0, t_e1 = 0, t_last = 0, t_rise = 0;
    bit lead_e;
    forever begin
      @(posedge clk); #1;
      if (rst_n) begin
        if (prev_pcs == 4'hF && pcs != 4'hF) begin
          t_fall = cyc; n_edge = 0; nb = 0; cap = '0;
          gap_meas = cyc - t_rise;
          chk("R8 selected line", {28'b0, pcs}, {28'b0, m_sel});
        end
        if (pcs != 4'hF && sck != prev_sck) begin
          lead_e = (prev_sck == m_cpol);
          n_edge++;
          if (n_edge == 1) begin lead_meas = cyc - t_fall; t_e1 = cyc; end
          if (n_edge == 3) per_meas = cyc - t_e1;
          if ((m_cpha ? !lead_e : lead_e) && nb <= m_fsz) begin
            if (m_lsb) cap[nb] = sout; else cap[m_fsz - nb] = sout;
            nb++;
          end
          t_last = cyc;
        end
        if (prev_pcs != 4'hF && pcs == 4'hF) begin
          trail_meas = cyc - t_last;
          t_rise = cyc;
          chk("R2 bit count", nb, m_fsz + 1);
          if (exp_q.size() == 0) chk("R2 unexpected frame", cap, 32'hxxxx_xxxx);
          else chk("R2 frame data", cap, exp_q.pop_front());
          frames_seen++;
        end
      end
      prev_pcs = pcs;
      prev_sck = sck;
    end
  end

  initial begin : watchdog
    #1_500_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    int base;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 pcs", {28'b0, pcs}, 32'hF);
    chk("R1 sck", {31'b0, sck}, 32'h0);
    chk("R1 sout", {31'b0, sout}, 32'h0);
    rd(AD_STAT, d); chk("R1 status", d, 32'h1);

    // Test A: cpha=1, MSB first, 32 bits, prescale 2^1, line 3
    config_cmd(0, 1, 0, 31, 1, 3, 0);
    wr(AD_TIME, {8'd5, 8'd2, 8'd3, 8'd4});
    send(32'hA5C3_1E7F, 1);
    send(32'h1234_5678, 1);
    wr(AD_CTRL, 32'h1);
    wait_frames(2);
    repeat (4) @(negedge clk);
    chk("R4 period A", per_meas, 12);
    chk("R5 lead A", lead_meas, 8);
    chk("R6 trail A", trail_meas, 6);
    chk("R7 gap A", gap_meas, 14);
    rd(AD_STAT, d); chk("R11 done+R10 rx_rdy", d, 32'h7);
    wr(AD_STAT, 32'h4);
    rd(AD_STAT, d); chk("R11 done cleared", d, 32'h3);
    rd(AD_RXD, d); chk("R10 rx word 1", d, 32'hA5C3_1E7F);
    rd(AD_RXD, d); chk("R10 rx word 2", d, 32'h1234_5678);
    rd(AD_STAT, d); chk("R10 rx_rdy low when empty", d & 32'h2, 32'h0);
    // R13 config locked while enabled
    wr(AD_CMD, mk_cmd(1, 0, 1, 7, 0, 0, 1));
    wr(AD_TIME, 32'hFFFF_FFFF);
    rd(AD_CMD, d); chk("R13 cmd locked", d, mk_cmd(0, 1, 0, 31, 1, 3, 0));
    rd(AD_TIME, d); chk("R13 timing locked", d, {8'd5, 8'd2, 8'd3, 8'd4});
    wr(AD_CTRL, 32'h0);

    // Test B: cpol=1, cpha=0, LSB first, 12 bits, no prescale, line 1
    config_cmd(1, 0, 1, 11, 0, 1, 0);
    wr(AD_TIME, 32'h0000_0001);
    wr(AD_WATER, 32'h11);
    @(negedge clk); #1;
    chk("R3 idle level cpol=1", {31'b0, sck}, 32'h1);
    base = frames_seen;
    send(32'h00AB_CDEF, 1);
    send(32'h0000_0731, 1);
    rd(AD_STAT, d); chk("R9 tx_req low above water", d & 32'h1, 32'h0);
    wr(AD_STAT, 32'h1);
    rd(AD_STAT, d); chk("R9 write has no effect", d & 32'h1, 32'h0);
    wr(AD_CTRL, 32'h1);
    wait_frames(base + 2);
    repeat (4) @(negedge clk);
    chk("R4 period B", per_meas, 3);
    chk("R5 lead B", lead_meas, 1);
    chk("R6 trail B", trail_meas, 1);
    chk("R7 gap B", gap_meas, 2);
    chk("R3 idle after frames", {31'b0, sck}, 32'h1);
    rd(AD_STAT, d); chk("R9 tx_req at water", d & 32'h1, 32'h1);
    chk("R10 rx_rdy above water", d & 32'h2, 32'h2);
    rd(AD_RXD, d); chk("R10 rx word B1", d, 32'h0000_0DEF);
    rd(AD_STAT, d); chk("R10 rx_rdy at water", d & 32'h2, 32'h0);
    rd(AD_RXD, d); chk("R10 rx word B2", d, 32'h0000_0731);
    wr(AD_CTRL, 32'h0);

    // Test C: overflow and receive stall, 8-bit frames, line 0
    config_cmd(0, 0, 0, 7, 0, 0, 0);
    wr(AD_TIME, 32'h0);
    wr(AD_WATER, 32'h0);
    wr(AD_STAT, 32'hC);
    base = frames_seen;
    send(32'h3C, 1); send(32'hA5, 1); send(32'h0F, 1); send(32'hF0, 1);
    send(32'h99, 0);
    rd(AD_STAT, d); chk("R12 overflow flag", d & 32'h8, 32'h8);
    wr(AD_CTRL, 32'h1);
    wait_frames(base + 4);
    send(32'h5A, 1); send(32'hC3, 1);
    repeat (60) @(negedge clk);
    chk("R14 stalled on full rx", frames_seen, base + 4);
    chk("R14 no chip select", {28'b0, pcs}, 32'hF);
    rd(AD_RXD, d); chk("R12 rx word 1", d, 32'h3C);
    rd(AD_RXD, d); chk("R12 rx word 2", d, 32'hA5);
    rd(AD_RXD, d); chk("R12 rx word 3", d, 32'h0F);
    rd(AD_RXD, d); chk("R12 rx word 4", d, 32'hF0);
    wait_frames(base + 6);
    repeat (4) @(negedge clk);
    rd(AD_RXD, d); chk("R14 resumed word 1", d, 32'h5A);
    rd(AD_RXD, d); chk("R14 resumed word 2", d, 32'hC3);
    wr(AD_STAT, 32'h8);
    rd(AD_STAT, d); chk("R12 overflow cleared", d & 32'h8, 32'h0);
    chk("R2 all frames consumed", exp_q.size(), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule